// File: doc/BRIEF.md
# SSI Absolute Angle Poller

This block reads one absolute rotary encoder over a synchronous serial link at a programmable rate and turns each reading into two parallel angles. A free-running sample timer counts system clocks and raises a tick whenever the programmed period has elapsed. On a tick, if the reader is idle, it drives a burst of clock pulses to the encoder and shifts in a frame: a Gray-coded shaft angle followed by two status bits.

At the end of each frame the angle is converted to plain binary and published as the raw angle. A corrected angle is formed at the same time by doubling the raw value and adding a zero offset, wrapping modulo the output width. Both angles update together with a one-cycle valid strobe. A status bit that reports a fault sets a sticky error flag, which stays set until the host clears it.

The reader is one state machine with five states. IDLE waits for a tick with the serial clock high. The *start* transition goes to CLK_LO. CLK_LO holds the clock low for a half period. The *rise* transition to CLK_HI samples one data bit. CLK_HI holds the clock high for a half period. It then takes the *next-bit* transition back to CLK_LO, or, once the whole frame is in, the *frame-end* transition to DONE. DONE lasts one cycle and publishes the results. The *publish* transition goes to GAP, which keeps the clock high for the encoder's idle time. The *rearm* transition then returns to IDLE. Ticks that arrive outside IDLE are dropped.

Top module: `ssi_angle_reader`

## Requirements
- R1: The sample period register resets to PERIOD_RST (1450). A one-cycle write on `period_wr_i` loads it and restarts the timer. A tick is raised every P system clock cycles, where P is the register value, and a read starts on a tick only while the reader is idle.
- R2: A tick that comes while a read or its idle gap is in progress is ignored. The next read starts on the first tick after the gap, so reads start exactly k·P cycles apart, where k is the smallest integer with k·P ≥ 34·HALF_CYC + IDLE_CYC + 2. A tick landing on exactly that cycle is accepted.
- R3: `ssi_clk_o` is high whenever no read is in progress. Each read gives exactly 17 low pulses. Each low phase lasts HALF_CYC cycles and each high phase lasts HALF_CYC cycles.
- R4: `ssi_data_i` is sampled on the cycle where the clock returns high, once per pulse, most significant bit first. The first 15 bits are the Gray-coded angle and the last 2 bits are status bits.
- R5: `raw_angle_o` is the binary equivalent of the received 15-bit Gray code. Bit 14 is the Gray bit 14, and each lower bit is the XOR of the Gray bits from 14 down to itself.
- R6: `corr_angle_o` equals `{raw_angle_o, 1'b0} + offset_i` modulo 2^16. `offset_i` is sampled in the last cycle of the read.
- R7: `raw_angle_o` and `corr_angle_o` change only in the cycle where `raw_valid_o` is high. `raw_valid_o` is a single-cycle pulse, one per read, and appears 34·HALF_CYC + 2 cycles after the start tick.
- R8: If either status bit of a frame is 1, `enc_err_o` is set, in the same cycle as that frame's `raw_valid_o`. It stays set until `err_clr_i` is high at a clock edge, and is cleared on the following cycle. If a clear and a new fault fall on the same edge, the flag stays set.
- R9: After reset `ssi_clk_o` is 1, `raw_valid_o` is 0, and both angles and `enc_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_wr_i | input | 1 | Load strobe for the sample period register |
| period_wdata_i | input | PERIOD_W | New sample period, in system clock cycles |
| offset_i | input | 16 | Zero offset added to the doubled angle |
| err_clr_i | input | 1 | Clears the sticky error flag |
| ssi_data_i | input | 1 | Serial data from the encoder |
| ssi_clk_o | output | 1 | Serial clock to the encoder, idles high |
| raw_angle_o | output | 15 | Binary angle from the last frame |
| raw_valid_o | output | 1 | One-cycle strobe when both angles update |
| corr_angle_o | output | 16 | Doubled angle plus offset |
| enc_err_o | output | 1 | Sticky encoder fault flag |

## Verification
Checked on every cycle: the valid strobe lasts a single cycle, and both angles hold steady between strobes. The corrected angle always equals the doubled raw angle plus the offset sampled one cycle earlier. The error flag never drops unless a clear was requested, and it only rises together with a strobe. The serial clock is high at each strobe. Only the bench scenarios show the parts that need a known encoder frame or elapsed time. These are the Gray decoding and bit order, the count and width of clock pulses, the spacing of reads for several periods (including a tick that lands exactly at the end of the gap and ticks that are dropped), the reset value of the period, and a clear that coincides with a new fault.

// File: rtl/ssi_reader_pkg.sv
package ssi_reader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLK_LO = 3'd1,
        ST_CLK_HI = 3'd2,
        ST_DONE   = 3'd3,
        ST_GAP    = 3'd4
    } rd_state_e;

endpackage

// File: rtl/ssi_sample_timer.sv
module ssi_sample_timer #(
    parameter int PERIOD_W   = 16,
    parameter int PERIOD_RST = 1450
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [PERIOD_W-1:0] wdata_i,
    output logic                tick_o
);

    localparam logic [PERIOD_W:0] ONE = {{PERIOD_W{1'b0}}, 1'b1};

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + ONE;
    assign tick_o  = (cnt_inc >= {1'b0, period_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= PERIOD_W'(PERIOD_RST);
            cnt_q    <= '0;
        end else if (wr_i) begin
            period_q <= wdata_i;
            cnt_q    <= '0;
        end else if (tick_o) begin
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_inc[PERIOD_W-1:0];
        end
    end

endmodule

// File: rtl/ssi_gray_to_bin.sv
module ssi_gray_to_bin #(
    parameter int W = 15
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin_o[i] = ^gray_i[W-1:i];
    end

endmodule

// File: rtl/ssi_frame_fsm.sv
module ssi_frame_fsm
    import ssi_reader_pkg::*;
#(
    parameter int FRAME_W  = 17,
    parameter int HALF_CYC = 20,
    parameter int IDLE_CYC = 800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               sdata_i,
    output logic               sclk_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] frame_o
);

    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int BW = $clog2(FRAME_W + 1);
    localparam int GW = $clog2(IDLE_CYC + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BITS_ALL  = BW'(FRAME_W);
    localparam logic [GW-1:0] GAP_LAST  = GW'(IDLE_CYC - 1);

    rd_state_e          state_q, state_d;
    logic [HW-1:0]      half_q;
    logic [BW-1:0]      bit_q;
    logic [GW-1:0]      gap_q;
    logic [FRAME_W-1:0] shift_q;
    logic               half_last, gap_last, rise;

    assign half_last = (half_q == HALF_LAST);
    assign gap_last  = (gap_q == GAP_LAST);
    assign rise      = (state_q == ST_CLK_LO) && half_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, rise, next-bit, frame-end, publish, rearm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick_i)    state_d = ST_CLK_LO;
            ST_CLK_LO: if (half_last) state_d = ST_CLK_HI;
            ST_CLK_HI: if (half_last) state_d = (bit_q == BITS_ALL) ? ST_DONE : ST_CLK_LO;
            ST_DONE:                  state_d = ST_GAP;
            ST_GAP:    if (gap_last)  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // phase, bit and gap counters, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            bit_q   <= '0;
            gap_q   <= '0;
            shift_q <= '0;
        end else begin
            half_q <= (state_d != state_q) ? '0 : half_q + 1'b1;
            gap_q  <= (state_q == ST_GAP) ? gap_q + 1'b1 : '0;
            if (state_q == ST_IDLE) begin
                bit_q <= '0;
            end else if (rise) begin
                bit_q   <= bit_q + 1'b1;
                shift_q <= {shift_q[FRAME_W-2:0], sdata_i};
            end
        end
    end

    // outputs
    always_comb begin
        sclk_o  = (state_q != ST_CLK_LO);
        done_o  = (state_q == ST_DONE);
        frame_o = shift_q;
    end

endmodule

// File: rtl/ssi_angle_reader.sv
module ssi_angle_reader #(
    parameter int ANGLE_W    = 15,
    parameter int STAT_W     = 2,
    parameter int PERIOD_W   = 16,
    parameter int PERIOD_RST = 1450,
    parameter int HALF_CYC   = 20,
    parameter int IDLE_CYC   = 800
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 period_wr_i,
    input  logic [PERIOD_W-1:0]  period_wdata_i,
    input  logic [ANGLE_W:0]     offset_i,
    input  logic                 err_clr_i,
    input  logic                 ssi_data_i,
    output logic                 ssi_clk_o,
    output logic [ANGLE_W-1:0]   raw_angle_o,
    output logic                 raw_valid_o,
    output logic [ANGLE_W:0]     corr_angle_o,
    output logic                 enc_err_o
);

    localparam int FRAME_W = ANGLE_W + STAT_W;
    localparam int OUT_W   = ANGLE_W + 1;

    logic               tick;
    logic               done;
    logic [FRAME_W-1:0] frame;
    logic [ANGLE_W-1:0] bin;
    logic [OUT_W-1:0]   corr_d;
    logic               fault;

    ssi_sample_timer #(
        .PERIOD_W  (PERIOD_W),
        .PERIOD_RST(PERIOD_RST)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (period_wr_i),
        .wdata_i(period_wdata_i),
        .tick_o (tick)
    );

    ssi_frame_fsm #(
        .FRAME_W (FRAME_W),
        .HALF_CYC(HALF_CYC),
        .IDLE_CYC(IDLE_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .sdata_i(ssi_data_i),
        .sclk_o (ssi_clk_o),
        .done_o (done),
        .frame_o(frame)
    );

    ssi_gray_to_bin #(.W(ANGLE_W)) u_g2b (
        .gray_i(frame[FRAME_W-1 -: ANGLE_W]),
        .bin_o (bin)
    );

    assign corr_d = {bin, 1'b0} + offset_i;
    assign fault  = |frame[STAT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_angle_o  <= '0;
            corr_angle_o <= '0;
            raw_valid_o  <= 1'b0;
            enc_err_o    <= 1'b0;
        end else begin
            raw_valid_o <= done;
            if (done) begin
                raw_angle_o  <= bin;
                corr_angle_o <= corr_d;
            end
            if (done && fault)  enc_err_o <= 1'b1;
            else if (err_clr_i) enc_err_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ssi_reader_checks.sv
module ssi_reader_checks #(
    parameter int ANGLE_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ANGLE_W:0]   offset_i,
    input logic               err_clr_i,
    input logic               ssi_clk_o,
    input logic [ANGLE_W-1:0] raw_angle_o,
    input logic               raw_valid_o,
    input logic [ANGLE_W:0]   corr_angle_o,
    input logic               enc_err_o
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid_o |=> !raw_valid_o); // R7

    AST_HOLD_ANGLES: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid_o |-> $stable(raw_angle_o) && $stable(corr_angle_o)); // R7

    AST_CORR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid_o |-> corr_angle_o == (ANGLE_W+1)'({raw_angle_o, 1'b0} + $past(offset_i))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err_o && !err_clr_i |=> enc_err_o); // R8

    AST_ERR_RISE_AT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_err_o) |-> raw_valid_o); // R8

    AST_CLK_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid_o |-> ssi_clk_o); // R3

endmodule

bind ssi_angle_reader ssi_reader_checks #(.ANGLE_W(ANGLE_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .offset_i    (offset_i),
    .err_clr_i   (err_clr_i),
    .ssi_clk_o   (ssi_clk_o),
    .raw_angle_o (raw_angle_o),
    .raw_valid_o (raw_valid_o),
    .corr_angle_o(corr_angle_o),
    .enc_err_o   (enc_err_o)
);

// File: tb/tb_ssi_angle_reader.sv
`timescale 1ns/1ps
module tb_ssi_angle_reader;

    localparam int HALF  = 2;
    localparam int IDLE  = 10;
    localparam int NVEC  = 7;
    localparam int LIMIT = 100000;

    // {binary angle[14:0], status[1:0], offset[15:0]}
    localparam logic [32:0] VEC [NVEC] = '{
        {15'h0000, 2'b00, 16'h0000},
        {15'h7FFF, 2'b00, 16'h0000},
        {15'h2AAA, 2'b00, 16'h1234},
        {15'h5555, 2'b00, 16'hFFFF},
        {15'h7FFF, 2'b00, 16'h0005},
        {15'h1234, 2'b01, 16'h0000},
        {15'h0F0F, 2'b00, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        period_wr = 1'b0;
    logic [15:0] period_wdata = '0;
    logic [15:0] offset = '0;
    logic        err_clr = 1'b0;
    logic        sdata = 1'b1;
    logic        sclk;
    logic [14:0] raw;
    logic        valid;
    logic [15:0] corr;
    logic        err;

    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          vcyc = 0;
    int          prev_vcyc = 0;
    int          falls = 0;
    int          bitk = 0;
    int          lo_run = 0;
    int          lo_min = 1000;
    int          lo_max = 0;
    logic [16:0] cur_frame = '0;
    logic        exp_err = 1'b0;

    ssi_angle_reader #(
        .HALF_CYC(HALF),
        .IDLE_CYC(IDLE)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_wr_i   (period_wr),
        .period_wdata_i(period_wdata),
        .offset_i      (offset),
        .err_clr_i     (err_clr),
        .ssi_data_i    (sdata),
        .ssi_clk_o     (sclk),
        .raw_angle_o   (raw),
        .raw_valid_o   (valid),
        .corr_angle_o  (corr),
        .enc_err_o     (err)
    );

    always #10 clk = ~clk;

    function automatic logic [14:0] to_gray(input logic [14:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected fewer)", LIMIT, cyc);
            summary_and_end();
        end
    end

    // encoder model: next bit after each falling clock edge, MSB first
    always @(negedge sclk) begin
        sdata = cur_frame[16 - bitk];
        bitk  = (bitk == 16) ? 0 : bitk + 1;
        falls++;
    end

    // low-phase width monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sclk) lo_run++;
            else if (lo_run != 0) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
                lo_run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        @(negedge clk);
        while (!valid) @(negedge clk);
        prev_vcyc = vcyc;
        vcyc = cyc;
    endtask

    task automatic load_vec(input logic [32:0] v);
        cur_frame = {to_gray(v[32:18]), v[17:16]};
        offset    = v[15:0];
    endtask

    task automatic write_period(input logic [15:0] p);
        @(negedge clk);
        period_wr    = 1'b1;
        period_wdata = p;
        @(negedge clk);
        period_wr    = 1'b0;
    endtask

    task automatic check_interval(input logic [15:0] p, input int expect_gap, input string tag);
        write_period(p);
        wait_valid();
        wait_valid();
        wait_valid();
        check(vcyc - prev_vcyc == expect_gap, tag, vcyc - prev_vcyc, expect_gap);
    endtask

    initial begin
        logic [14:0] ea;
        logic [15:0] ec;
        load_vec(VEC[0]);
        repeat (3) @(negedge clk);
        // R9: reset state
        check(sclk == 1'b1, "R9 clock idle", sclk, 1);
        check(valid == 1'b0, "R9 valid", valid, 0);
        check(raw == '0 && corr == '0, "R9 angles", {raw, corr}, 0);
        check(err == 1'b0, "R9 error flag", err, 0);
        rst_n = 1'b1;

        // vector table: R4/R5 decode, R6 correction, R8 flag, R1 default period
        for (int i = 0; i < NVEC; i++) begin
            wait_valid();
            ea = VEC[i][32:18];
            ec = {ea, 1'b0} + VEC[i][15:0];
            if (VEC[i][17:16] != 2'b00) exp_err = 1'b1;
            check(raw == ea, "R5 raw angle", raw, ea);
            check(corr == ec, "R6 corrected angle", corr, ec);
            check(err == exp_err, "R8 error flag", err, exp_err);
            check(falls == 17, "R3 pulses per read", falls, 17);
            falls = 0;
            if (i > 0) check(vcyc - prev_vcyc == 1450, "R1 default period", vcyc - prev_vcyc, 1450);
            if (i + 1 < NVEC) load_vec(VEC[i + 1]);
        end
        check(lo_min == HALF && lo_max == HALF, "R3 low phase width", {lo_min[15:0], lo_max[15:0]}, {16'(HALF), 16'(HALF)});

        // R8: plain clear, R7: angles unchanged without a read
        load_vec({15'h0101, 2'b10, 16'h0000});
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(err == 1'b0, "R8 clear", err, 0);
        check(raw == 15'h0F0F, "R7 hold raw", raw, 15'h0F0F);

        // second status bit sets the flag
        wait_valid();
        check(err == 1'b1, "R8 second status bit", err, 1);
        check(raw == 15'h0101, "R4 bit order", raw, 15'h0101);

        // R8: clear on the same edge as a new fault; the flag stays set
        repeat (1450 - 1) @(posedge clk);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(valid == 1'b1, "R8 alignment with read", valid, 1);
        check(err == 1'b1, "R8 set beats clear", err, 1);
        @(negedge clk);
        check(valid == 1'b0, "R7 single-cycle pulse", valid, 0);

        load_vec({15'h0000, 2'b00, 16'h0000});
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(err == 1'b0, "R8 clear after", err, 0);

        // R2: read length is 34*2+10+2 = 80 cycles
        check_interval(16'd40, 80, "R2 tick exactly at gap end");
        check_interval(16'd30, 90, "R2 dropped ticks");
        check_interval(16'd100, 100, "R1 written period");
        check(raw == 15'h0000 && corr == 16'h0000, "R6 zero angle", {raw, corr}, 0);

        summary_and_end();
    end

endmodule